// File: doc/BRIEF.md
# Register-Change Recovery Logger

This block keeps a short history of the general-register side effects that one instruction has produced. Each time the address logic steps a register up or down, it presents a strobe carrying the register number and the signed size of the step. The logger packs that pair into an 8-bit entry and places it in the next free byte of a 16-bit log word. After an abort, recovery software reads the word and reverses the listed changes before it restarts the instruction.

A small write counter picks the byte for each entry. The first entry always lands in the low byte and the second in the high byte, even when both entries name the same register. Two changes are therefore never summed into one entry. A pulse at the start of each instruction empties the log. A freeze input, driven by the error bits of the surrounding control register, holds the log and the counter so that the record of a faulting instruction survives until software has read it.

Top module: `rcl_logger`

## Requirements
- R1: While `rst_n` is low, the log clears to 0. The counter returns to the empty state.
- R2: Each byte of `log_value` is one entry. Bits 7:3 of the byte hold the step as a 5-bit two's-complement value, and bits 2:0 hold the register number. The low byte is `log_value[7:0]` and the high byte is `log_value[15:8]`.
- R3: The first accepted strobe after a clear writes its entry into the low byte and leaves the high byte at 0. It is visible on `log_value` one clock after the strobe.
- R4: The second accepted strobe writes the high byte and leaves the low byte unchanged, whatever registers the two strobes name. Two steps of +2 on register 7 read back as octal 013427 (hex 1717).
- R5: Once both bytes hold entries, further strobes in the same instruction leave `log_value` unchanged.
- R6: When `freeze` is low, `instr_start` clears both bytes and empties the counter. A strobe in the same cycle is discarded.
- R7: While `freeze` is high, strobes and `instr_start` have no effect. The log and the counter position are both kept, so logging resumes in the next free byte when `freeze` falls.
- R8: After `freeze` falls, the next `instr_start` clears the log.
- R9: A negative step is stored in two's complement. For example, -2 is stored as 11110, so -2 on register 2 gives the byte hex F2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_start | input | 1 | One-cycle pulse at the start of each instruction |
| log_valid | input | 1 | Strobe: one register step to record |
| log_reg | input | 3 | Number of the register that was stepped |
| log_delta | input | 5 | Signed step size, two's complement |
| freeze | input | 1 | High while an error bit of the control register is set |
| log_value | output | 16 | Log word: high byte is the second entry, low byte is the first |

## Verification
The assertions assume that `freeze`, `instr_start` and the strobe fields are settled at each rising edge. They also assume that a strobe's register and step fields belong to that cycle, because the stored byte is compared with the fields sampled one edge earlier. The bench drives every input a quarter period after the rising edge, which keeps all of them settled, and it never relies on any field outside an active strobe. Strobe counts of one, two and three per instruction, freezes that start mid-instruction, and a start pulse coinciding with a strobe are driven on purpose. A random phase then mixes all inputs, and a behavioural model follows it on every clock.

// File: rtl/rcl_pkg.sv
// Shared defaults for the register-change recovery logger.
// Assumes: nothing; holds only constants used as parameter defaults.
package rcl_pkg;
    localparam int DEF_REG_W   = 3;  // register number width
    localparam int DEF_DELTA_W = 5;  // signed step width
    localparam int DEF_SLOTS   = 2;  // entries per instruction
endpackage

// File: rtl/rcl_wr_counter.sv
// Write counter: counts accepted entries from 0 up to NUM_SLOTS and
// saturates there. Assumes clear and advance are never high together
// (the parent gives clear priority).
module rcl_wr_counter #(
    parameter int NUM_SLOTS = 2,
    localparam int CW = $clog2(NUM_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [CW-1:0] cnt,
    output logic          full
);
    localparam logic [CW-1:0] LAST = CW'(NUM_SLOTS);

    // Step the count on each accepted entry, return to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (advance && !full)
            cnt <= cnt + 1'b1;
    end

    // Saturation flag: every slot is taken.
    always_comb full = (cnt == LAST);
endmodule

// File: rtl/rcl_slot.sv
// One log entry register of W bits with a synchronous clear.
// Assumes the parent raises wr_en for at most one slot per cycle.
module rcl_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         wr_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Hold the entry; clear has priority over a write.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            q <= '0;
        else if (wr_en)
            q <= din;
    end
endmodule

// File: rtl/rcl_logger.sv
// Register-change recovery logger. Each accepted strobe is packed as
// {step, register} into the next free slot; slot 0 sits in the low bits.
// Assumes the freeze input already reflects the control register's error
// bits, and that instr_start is a single-cycle pulse per instruction.
module rcl_logger
    import rcl_pkg::*;
#(
    parameter int REG_W   = DEF_REG_W,
    parameter int DELTA_W = DEF_DELTA_W,
    parameter int SLOTS   = DEF_SLOTS,
    localparam int ENT_W  = REG_W + DELTA_W,
    localparam int LOG_W  = ENT_W * SLOTS,
    localparam int CW     = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_start,
    input  logic               log_valid,
    input  logic [REG_W-1:0]   log_reg,
    input  logic [DELTA_W-1:0] log_delta,
    input  logic               freeze,
    output logic [LOG_W-1:0]   log_value
);
    logic          clr_log;
    logic          accept;
    logic          cnt_full;
    logic [CW-1:0] wr_cnt;
    logic [ENT_W-1:0] entry;

    // Decode control: freeze blocks everything, start beats a strobe.
    always_comb begin
        clr_log = instr_start && !freeze;
        accept  = log_valid && !freeze && !instr_start && !cnt_full;
        entry   = {log_delta, log_reg};
    end

    rcl_wr_counter #(.NUM_SLOTS(SLOTS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr_log),
        .advance (accept),
        .cnt     (wr_cnt),
        .full    (cnt_full)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic sel;
        // Select this slot when the counter points at it.
        always_comb sel = accept && (wr_cnt == CW'(i));

        rcl_slot #(.W(ENT_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clr_log),
            .wr_en (sel),
            .din   (entry),
            .q     (log_value[i*ENT_W +: ENT_W])
        );
    end
endmodule

// File: rtl/rcl_logger_chk.sv
// Assertion checker for rcl_logger, attached by bind below.
// Assumes it sees the top's ports plus the internal write count.
module rcl_logger_chk #(
    parameter int REG_W   = 3,
    parameter int DELTA_W = 5,
    parameter int SLOTS   = 2,
    localparam int ENT_W  = REG_W + DELTA_W,
    localparam int LOG_W  = ENT_W * SLOTS,
    localparam int CW     = $clog2(SLOTS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_start,
    input logic               log_valid,
    input logic [REG_W-1:0]   log_reg,
    input logic [DELTA_W-1:0] log_delta,
    input logic               freeze,
    input logic [LOG_W-1:0]   log_value,
    input logic [CW-1:0]      wr_cnt
);
    localparam logic [CW-1:0] CNT_FULL = CW'(SLOTS);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (log_value == '0));

    assert_first_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !freeze && !instr_start && wr_cnt == '0)
        |=> (log_value[ENT_W-1:0] == $past({log_delta, log_reg}))
            && (log_value[LOG_W-1:ENT_W] == '0));

    assert_second_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !freeze && !instr_start && wr_cnt == CW'(1))
        |=> (log_value[2*ENT_W-1:ENT_W] == $past({log_delta, log_reg}))
            && $stable(log_value[ENT_W-1:0]));

    assert_extra_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !instr_start && wr_cnt == CNT_FULL) |=> $stable(log_value));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= CNT_FULL);

    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_start && !freeze) |=> (log_value == '0) && (wr_cnt == '0));

    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(log_value) && $stable(wr_cnt));
endmodule

bind rcl_logger rcl_logger_chk #(
    .REG_W(REG_W), .DELTA_W(DELTA_W), .SLOTS(SLOTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_start (instr_start),
    .log_valid   (log_valid),
    .log_reg     (log_reg),
    .log_delta   (log_delta),
    .freeze      (freeze),
    .log_value   (log_value),
    .wr_cnt      (wr_cnt)
);

// File: tb/tb_rcl_logger.sv
// Bench for rcl_logger: directed cases plus a random phase, with a
// behavioural model compared on every falling edge.
module tb_rcl_logger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_start = 1'b0;
    logic        log_valid = 1'b0;
    logic [2:0]  log_reg = '0;
    logic [4:0]  log_delta = '0;
    logic        freeze = 1'b0;
    logic [15:0] log_value;

    int checks = 0;
    int errors = 0;
    int m_byte[2];
    int m_used = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    rcl_logger dut (
        .clk(clk), .rst_n(rst_n), .instr_start(instr_start),
        .log_valid(log_valid), .log_reg(log_reg), .log_delta(log_delta),
        .freeze(freeze), .log_value(log_value)
    );

    // Reference model: byte list filled in order, cleared per instruction.
    initial begin m_byte[0] = 0; m_byte[1] = 0; end
    always @(posedge clk) begin
        if (!rst_n) begin
            m_byte[0] = 0; m_byte[1] = 0; m_used = 0;
        end else if (!freeze) begin
            if (instr_start) begin
                m_byte[0] = 0; m_byte[1] = 0; m_used = 0;
            end else if (log_valid && m_used < 2) begin
                m_byte[m_used] = ((int'(log_delta) & 31) * 8) + int'(log_reg);
                m_used = m_used + 1;
            end
        end
    end

    // Continuous comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(log_value) != m_byte[1] * 256 + m_byte[0]) begin
                errors++;
                $display("FAIL R2 model compare: actual %h expected %h",
                         log_value, m_byte[1] * 256 + m_byte[0]);
            end
        end
    end

    task automatic check(string tag, logic [15:0] exp);
        checks++;
        if (log_value !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, log_value, exp);
        end
    endtask

    // Apply one cycle of inputs, then wait until just after the edge.
    task automatic cyc(bit s, bit v, int r, int d, bit f);
        instr_start = s;
        log_valid   = v;
        log_reg     = 3'(r);
        log_delta   = 5'(d);
        freeze      = f;
        @(posedge clk);
        #5;
    endtask

    task automatic idle(bit f);
        cyc(0, 0, 0, 0, f);
    endtask

    initial begin
        #4_000_000;
        $display("FAIL watchdog: actual timeout expected finish");
        errors++;
        checks++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset value", 16'h0000);
        rst_n = 1'b1;

        // R3 single entry in low byte, R2 field layout
        cyc(1, 0, 0, 0, 0);
        check("R6 start clears", 16'h0000);
        cyc(0, 1, 3, 2, 0);
        check("R3 single +2 r3 in low byte", 16'h0013);
        idle(0);

        // R4 two +2 on r7 kept separate (octal 013427)
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 7, 2, 0);
        check("R3 first +2 r7", 16'h0017);
        cyc(0, 1, 7, 2, 0);
        check("R4 same register twice", 16'o013427);
        cyc(0, 1, 1, -1, 0);
        check("R5 third strobe ignored", 16'o013427);
        cyc(0, 1, 4, 3, 0);
        check("R5 fourth strobe ignored", 16'o013427);

        // R4 different registers, R9 negative step
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 2, -2, 0);
        check("R9 -2 r2 two's complement", 16'h00F2);
        cyc(0, 1, 5, 1, 0);
        check("R4 different registers", 16'h0DF2);

        // R7 freeze holds contents and ignores start and strobes
        cyc(0, 0, 0, 0, 1);
        cyc(0, 1, 6, 4, 1);
        check("R7 strobe while frozen", 16'h0DF2);
        cyc(1, 0, 0, 0, 1);
        check("R7 start while frozen", 16'h0DF2);
        idle(0);
        check("R7 release keeps contents", 16'h0DF2);
        cyc(1, 0, 0, 0, 0);
        check("R8 start after release clears", 16'h0000);

        // R7 freeze mid-instruction keeps counter position
        cyc(0, 1, 1, 1, 0);
        check("R3 +1 r1", 16'h0009);
        cyc(0, 1, 2, 2, 1);
        check("R7 mid-instruction freeze", 16'h0009);
        cyc(0, 1, 4, 2, 0);
        check("R7 resume into high byte", 16'h1409);

        // R6 start wins over simultaneous strobe
        cyc(1, 1, 6, 3, 0);
        check("R6 start with strobe", 16'h0000);
        cyc(0, 1, 0, -16, 0);
        check("R9 most negative step", 16'h0080);

        // Random phase checked by the model
        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 5) == 0, ($urandom % 2) == 0, int'($urandom % 8),
                int'($urandom % 32), ($urandom % 6) == 0);
        end

        // R1 reset mid-run
        rst_n = 1'b0;
        cyc(0, 1, 3, 3, 0);
        check("R1 reset mid-run", 16'h0000);
        rst_n = 1'b1;
        idle(0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule